// File: doc/BRIEF.md
# Command Interpreter Pipeline

The block takes host I/O requests and turns them into flash commands that each cover one super page, a group of four 2 KB pages. It is a four-stage pipeline. The first stage holds the request and walks through it one super page at a time. The second stage asks the write buffer whether that super page is present. The third stage sends write-buffer misses to a mapping lookup port and waits for the physical super page. The fourth stage splits the physical address into module, super-chip, super-block and super-page fields and hands the command to the agent of that module. A command that hit in the write buffer is handed to a separate hit port instead. Hit commands still pass through the translation stage, so every command keeps its place in order.

Each request carries a two-bit buffer-feeder slot tag and a write flag, and every command produced from that request repeats both. Every stage moves data with a valid/ready handshake, so a stalled agent or a slow mapping fill holds the whole pipeline without losing or duplicating any command. While no request is accepted for a set number of cycles, the block raises a single garbage-collection pulse.

Top module: `cmd_interp_pipe`

## Requirements
- R1: While reset is held, reqReady is 1 and agentValid, hitValid, mapReqValid, wbProbeValid and gcTrigger are all 0.
- R2: A request names a first 2 KB page P and a count M1 (pages minus one). Its commands cover the logical super pages P>>2 through (P+M1)>>2, both wrapping modulo the address width. Each one is emitted exactly once, in ascending order. reqReady is low from the cycle after acceptance until the last command of the request has left the first stage.
- R3: Every command is probed on wbProbeLsp. A hit (wbHit=1) is delivered on the hit port with no mapping handshake. A miss makes exactly one mapRespValid handshake.
- R4: A miss drives mapReqValid with its logical super page and holds both until mapRespValid. Later commands wait behind it.
- R5: The physical super page is decoded with bits [1:0] as the module, [3:2] as the super-chip, [SPG_W+3:4] as the super page and the remaining upper bits as the super block. At most one of agentValid and hitValid is asserted, and only the agentValid bit of the decoded module.
- R6: While the selected agent, or the hit port, is not ready, the offered command stays valid and unchanged, and no later command overtakes it.
- R7: Every command carries the slot tag and write flag of its request unchanged.
- R8: If no request is accepted for IDLE_LIMIT consecutive clock edges after an acceptance, gcTrigger pulses high for exactly one cycle, IDLE_LIMIT edges after the accepting edge. It pulses again only after a later request is accepted.
- R9: With every stage free and an immediate mapping response, a request's first command is offered three clock edges after the accepting edge, and the following commands on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request offered |
| reqReady | output | 1 | Analysis stage can take a request |
| reqWrite | input | 1 | Request is a write |
| reqSlot | input | SLOT_W | Buffer-feeder slot tag |
| reqPage | input | PAGE_W | First 2 KB page of the request |
| reqPagesM1 | input | LEN_W | Page count minus one |
| wbProbeValid | output | 1 | Write-buffer probe active |
| wbProbeLsp | output | PAGE_W-2 | Logical super page probed |
| wbProbeWrite | output | 1 | Probed command is a write |
| wbHit | input | 1 | Probed super page is in the write buffer |
| mapReqValid | output | 1 | Mapping lookup pending |
| mapReqLsp | output | PAGE_W-2 | Logical super page to translate |
| mapRespValid | input | 1 | Mapping result available |
| mapRespPsp | input | PSP_W | Physical super page |
| agentValid | output | NUM_MODULES | Command offered to module agent |
| agentReady | input | NUM_MODULES | Agent takes the command |
| hitValid | output | 1 | Write-buffer hit command offered |
| hitReady | input | 1 | Hit port takes the command |
| cmdLsp | output | PAGE_W-2 | Logical super page of the command |
| cmdWrite | output | 1 | Command is a write |
| cmdSlot | output | SLOT_W | Slot tag of the command |
| cmdChip | output | CHIP_W | Target super-chip |
| cmdBlock | output | BLK_W | Target super block |
| cmdPage | output | SPG_W | Target super page within the block |
| gcTrigger | output | 1 | One-cycle garbage-collection request |

## Verification
A wrong stage-valid bit shows up at the command ports within one to three cycles, either as a missing command or as a repeated one. Because the bench compares the count and order of delivered super pages against the split of each request, both errors are caught. A lost mapping response or a wrongly held stage-three entry shows up as a stuck mapReqValid or a wrong target field on the very next delivered command. A mis-sliced address field differs from the bench's own decode on the first routed command. An idle counter that is off by one, or that never saturates, moves the gcTrigger pulse away from its expected edge or makes it repeat, and this is visible within IDLE_LIMIT cycles.

// File: rtl/cip_pkg.sv
package cip_pkg;

  // Strobes from control to datapath, one per register-load event
  typedef struct packed {
    logic acceptReq;  // capture a new request into stage 1
    logic stepLsp;    // advance stage-1 super-page pointer
    logic loadS2;     // move stage 1 into stage 2
    logic loadS3;     // move stage 2 into stage 3
    logic captPsp;    // park a mapping response in stage 3
    logic useStored;  // stage 3 already holds its physical page
    logic loadS4;     // move stage 3 into stage 4
  } cipStrobes_t;

endpackage

// File: rtl/cip_target_split.sv
module cip_target_split #(
  parameter int MOD_W  = 2,
  parameter int CHIP_W = 2,
  parameter int SPG_W  = 6,
  parameter int BLK_W  = 10,
  localparam int PSP_W = MOD_W + CHIP_W + SPG_W + BLK_W
) (
  input  logic [PSP_W-1:0]  psp,
  output logic [MOD_W-1:0]  tgtModule,
  output logic [CHIP_W-1:0] tgtChip,
  output logic [SPG_W-1:0]  tgtPage,
  output logic [BLK_W-1:0]  tgtBlock
);

  localparam int CHIP_LO = MOD_W;
  localparam int PAGE_LO = MOD_W + CHIP_W;
  localparam int BLK_LO  = MOD_W + CHIP_W + SPG_W;

  // Low bits interleave modules, then chips, so consecutive pages spread out
  assign tgtModule = psp[MOD_W-1:0];
  assign tgtChip   = psp[CHIP_LO +: CHIP_W];
  assign tgtPage   = psp[PAGE_LO +: SPG_W];
  assign tgtBlock  = psp[BLK_LO +: BLK_W];

endmodule

// File: rtl/cip_ctrl.sv
module cip_ctrl
  import cip_pkg::*;
#(
  parameter int NUM_MODULES = 4,
  parameter int IDLE_LIMIT  = 1000,
  parameter int IDLE_W      = 16,
  localparam int MOD_W      = $clog2(NUM_MODULES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   s1Last,
  input  logic                   s3Hit,
  input  logic                   s4Hit,
  input  logic [MOD_W-1:0]       s4Module,
  output logic                   wbProbeValid,
  output logic                   mapReqValid,
  input  logic                   mapRespValid,
  output logic [NUM_MODULES-1:0] agentValid,
  input  logic [NUM_MODULES-1:0] agentReady,
  output logic                   hitValid,
  input  logic                   hitReady,
  output logic                   gcTrigger,
  output cipStrobes_t            stb
);

  localparam logic [IDLE_W-1:0] IDLE_END = IDLE_W'(IDLE_LIMIT);
  localparam logic [IDLE_W-1:0] IDLE_PRE = IDLE_W'(IDLE_LIMIT - 1);

  logic s1Busy, s2Valid, s3Valid, s3Have, s4Valid;
  logic s4Drain, s4Free, s3Go, s3Free, s2Go, s2Free, s1Go, accept;
  logic [IDLE_W-1:0] idleCnt;
  logic gcPulse;

  // Ready chain from the output back to the request port
  always_comb begin
    s4Drain = s4Valid && (s4Hit ? hitReady : agentReady[s4Module]);
    s4Free  = !s4Valid || s4Drain;
    s3Go    = s3Valid && (s3Hit || s3Have || mapRespValid) && s4Free;
    s3Free  = !s3Valid || s3Go;
    s2Go    = s2Valid && s3Free;
    s2Free  = !s2Valid || s2Go;
    s1Go    = s1Busy && s2Free;
    accept  = reqValid && !s1Busy;
  end

  assign reqReady     = !s1Busy;
  assign wbProbeValid = s1Busy;
  assign mapReqValid  = s3Valid && !s3Hit && !s3Have;
  assign hitValid     = s4Valid && s4Hit;
  assign gcTrigger    = gcPulse;

  for (genvar m = 0; m < NUM_MODULES; m++) begin : g_agent
    assign agentValid[m] = s4Valid && !s4Hit && (s4Module == MOD_W'(m));
  end

  always_comb begin
    stb.acceptReq = accept;
    stb.stepLsp   = s1Go && !s1Last;
    stb.loadS2    = s1Go;
    stb.loadS3    = s2Go;
    stb.captPsp   = mapReqValid && mapRespValid && !s3Go;
    stb.useStored = s3Have;
    stb.loadS4    = s3Go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Busy  <= 1'b0;
      s2Valid <= 1'b0;
      s3Valid <= 1'b0;
      s3Have  <= 1'b0;
      s4Valid <= 1'b0;
    end else begin
      if (accept)               s1Busy <= 1'b1;
      else if (s1Go && s1Last)  s1Busy <= 1'b0;
      if (s2Free) s2Valid <= s1Go;
      if (s3Free) s3Valid <= s2Go;
      if (s4Free) s4Valid <= s3Go;
      if (s3Go)               s3Have <= 1'b0;
      else if (stb.captPsp)   s3Have <= 1'b1;
    end
  end

  // Saturating idle counter: one pulse per idle stretch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
      gcPulse <= 1'b0;
    end else begin
      gcPulse <= !accept && (idleCnt == IDLE_PRE);
      if (accept)                 idleCnt <= '0;
      else if (idleCnt != IDLE_END) idleCnt <= idleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/cip_datapath.sv
module cip_datapath
  import cip_pkg::*;
#(
  parameter int PAGE_W  = 24,
  parameter int LEN_W   = 8,
  parameter int SLOT_W  = 2,
  parameter int MOD_W   = 2,
  parameter int CHIP_W  = 2,
  parameter int SPG_W   = 6,
  parameter int BLK_W   = 10,
  parameter int SP_SHIFT = 2,
  localparam int LSP_W  = PAGE_W - SP_SHIFT,
  localparam int PSP_W  = MOD_W + CHIP_W + SPG_W + BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cipStrobes_t       stb,
  input  logic              reqWrite,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [LEN_W-1:0]  reqPagesM1,
  input  logic              wbHit,
  input  logic [PSP_W-1:0]  mapRespPsp,
  output logic              s1Last,
  output logic              s3Hit,
  output logic              s4Hit,
  output logic [MOD_W-1:0]  s4Module,
  output logic [LSP_W-1:0]  wbProbeLsp,
  output logic              wbProbeWrite,
  output logic [LSP_W-1:0]  mapReqLsp,
  output logic [LSP_W-1:0]  cmdLsp,
  output logic              cmdWrite,
  output logic [SLOT_W-1:0] cmdSlot,
  output logic [CHIP_W-1:0] cmdChip,
  output logic [BLK_W-1:0]  cmdBlock,
  output logic [SPG_W-1:0]  cmdPage
);

  logic [PAGE_W-1:0] endPage;
  logic [LSP_W-1:0]  curLsp, lastLsp, s2Lsp, s3Lsp, s4Lsp;
  logic              s1Write, s2Write, s3Write, s4Write;
  logic [SLOT_W-1:0] s1Slot, s2Slot, s3Slot, s4Slot;
  logic              s2Hit;
  logic [PSP_W-1:0]  s3Psp, s4Psp, pspIn;

  assign endPage      = reqPage + PAGE_W'(reqPagesM1);
  assign s1Last       = (curLsp == lastLsp);
  assign wbProbeLsp   = curLsp;
  assign wbProbeWrite = s1Write;
  assign mapReqLsp    = s3Lsp;
  assign pspIn        = s3Hit ? '0 : (stb.useStored ? s3Psp : mapRespPsp);

  // Stage 1: request analysis, super-page walk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curLsp  <= '0;
      lastLsp <= '0;
      s1Write <= 1'b0;
      s1Slot  <= '0;
    end else if (stb.acceptReq) begin
      curLsp  <= reqPage[PAGE_W-1:SP_SHIFT];
      lastLsp <= endPage[PAGE_W-1:SP_SHIFT];
      s1Write <= reqWrite;
      s1Slot  <= reqSlot;
    end else if (stb.stepLsp) begin
      curLsp  <= curLsp + 1'b1;
    end
  end

  // Stage 2: write-buffer probe result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2Lsp   <= '0;
      s2Write <= 1'b0;
      s2Slot  <= '0;
      s2Hit   <= 1'b0;
    end else if (stb.loadS2) begin
      s2Lsp   <= curLsp;
      s2Write <= s1Write;
      s2Slot  <= s1Slot;
      s2Hit   <= wbHit;
    end
  end

  // Stage 3: translation, with a parked copy of the fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3Lsp   <= '0;
      s3Write <= 1'b0;
      s3Slot  <= '0;
      s3Hit   <= 1'b0;
      s3Psp   <= '0;
    end else begin
      if (stb.loadS3) begin
        s3Lsp   <= s2Lsp;
        s3Write <= s2Write;
        s3Slot  <= s2Slot;
        s3Hit   <= s2Hit;
      end
      if (stb.captPsp) s3Psp <= mapRespPsp;
    end
  end

  // Stage 4: emission register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s4Lsp   <= '0;
      s4Write <= 1'b0;
      s4Slot  <= '0;
      s4Hit   <= 1'b0;
      s4Psp   <= '0;
    end else if (stb.loadS4) begin
      s4Lsp   <= s3Lsp;
      s4Write <= s3Write;
      s4Slot  <= s3Slot;
      s4Hit   <= s3Hit;
      s4Psp   <= pspIn;
    end
  end

  cip_target_split #(
    .MOD_W (MOD_W),
    .CHIP_W(CHIP_W),
    .SPG_W (SPG_W),
    .BLK_W (BLK_W)
  ) u_split (
    .psp      (s4Psp),
    .tgtModule(s4Module),
    .tgtChip  (cmdChip),
    .tgtPage  (cmdPage),
    .tgtBlock (cmdBlock)
  );

  assign cmdLsp   = s4Lsp;
  assign cmdWrite = s4Write;
  assign cmdSlot  = s4Slot;

endmodule

// File: rtl/cmd_interp_pipe.sv
module cmd_interp_pipe
  import cip_pkg::*;
#(
  parameter int PAGE_W           = 24,
  parameter int LEN_W            = 8,
  parameter int SLOT_W           = 2,
  parameter int NUM_MODULES      = 4,
  parameter int CHIPS_PER_MODULE = 4,
  parameter int PAGES_PER_SUPER  = 4,
  parameter int SPG_W            = 6,
  parameter int BLK_W            = 10,
  parameter int IDLE_LIMIT       = 1000,
  localparam int MOD_W    = $clog2(NUM_MODULES),
  localparam int CHIP_W   = $clog2(CHIPS_PER_MODULE),
  localparam int SP_SHIFT = $clog2(PAGES_PER_SUPER),
  localparam int LSP_W    = PAGE_W - SP_SHIFT,
  localparam int PSP_W    = MOD_W + CHIP_W + SPG_W + BLK_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [SLOT_W-1:0]      reqSlot,
  input  logic [PAGE_W-1:0]      reqPage,
  input  logic [LEN_W-1:0]       reqPagesM1,
  output logic                   wbProbeValid,
  output logic [LSP_W-1:0]       wbProbeLsp,
  output logic                   wbProbeWrite,
  input  logic                   wbHit,
  output logic                   mapReqValid,
  output logic [LSP_W-1:0]       mapReqLsp,
  input  logic                   mapRespValid,
  input  logic [PSP_W-1:0]       mapRespPsp,
  output logic [NUM_MODULES-1:0] agentValid,
  input  logic [NUM_MODULES-1:0] agentReady,
  output logic                   hitValid,
  input  logic                   hitReady,
  output logic [LSP_W-1:0]       cmdLsp,
  output logic                   cmdWrite,
  output logic [SLOT_W-1:0]      cmdSlot,
  output logic [CHIP_W-1:0]      cmdChip,
  output logic [BLK_W-1:0]       cmdBlock,
  output logic [SPG_W-1:0]       cmdPage,
  output logic                   gcTrigger
);

  cipStrobes_t      stb;
  logic             s1Last, s3Hit, s4Hit;
  logic [MOD_W-1:0] s4Module;

  cip_ctrl #(
    .NUM_MODULES(NUM_MODULES),
    .IDLE_LIMIT (IDLE_LIMIT)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .s1Last      (s1Last),
    .s3Hit       (s3Hit),
    .s4Hit       (s4Hit),
    .s4Module    (s4Module),
    .wbProbeValid(wbProbeValid),
    .mapReqValid (mapReqValid),
    .mapRespValid(mapRespValid),
    .agentValid  (agentValid),
    .agentReady  (agentReady),
    .hitValid    (hitValid),
    .hitReady    (hitReady),
    .gcTrigger   (gcTrigger),
    .stb         (stb)
  );

  cip_datapath #(
    .PAGE_W  (PAGE_W),
    .LEN_W   (LEN_W),
    .SLOT_W  (SLOT_W),
    .MOD_W   (MOD_W),
    .CHIP_W  (CHIP_W),
    .SPG_W   (SPG_W),
    .BLK_W   (BLK_W),
    .SP_SHIFT(SP_SHIFT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .reqWrite    (reqWrite),
    .reqSlot     (reqSlot),
    .reqPage     (reqPage),
    .reqPagesM1  (reqPagesM1),
    .wbHit       (wbHit),
    .mapRespPsp  (mapRespPsp),
    .s1Last      (s1Last),
    .s3Hit       (s3Hit),
    .s4Hit       (s4Hit),
    .s4Module    (s4Module),
    .wbProbeLsp  (wbProbeLsp),
    .wbProbeWrite(wbProbeWrite),
    .mapReqLsp   (mapReqLsp),
    .cmdLsp      (cmdLsp),
    .cmdWrite    (cmdWrite),
    .cmdSlot     (cmdSlot),
    .cmdChip     (cmdChip),
    .cmdBlock    (cmdBlock),
    .cmdPage     (cmdPage)
  );

endmodule

// File: rtl/cip_checker.sv
module cip_checker #(
  parameter int LSP_W       = 22,
  parameter int NUM_MODULES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reqValid,
  input logic                   reqReady,
  input logic                   mapReqValid,
  input logic                   mapRespValid,
  input logic [LSP_W-1:0]       mapReqLsp,
  input logic [NUM_MODULES-1:0] agentValid,
  input logic [NUM_MODULES-1:0] agentReady,
  input logic                   hitValid,
  input logic                   hitReady,
  input logic [LSP_W-1:0]       cmdLsp,
  input logic                   gcTrigger
);

  // R5: a single destination per offered command
  assert_agent_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(agentValid))
    else $error("agentValid not one-hot");

  assert_hit_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hitValid |-> (agentValid == '0))
    else $error("hit and agent offered together");

  // R6: stalled command is held
  assert_agent_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((agentValid & ~agentReady) != '0) |=> ($stable(agentValid) && $stable(cmdLsp)))
    else $error("agent command changed under stall");

  assert_hit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hitValid && !hitReady) |=> (hitValid && $stable(cmdLsp)))
    else $error("hit command changed under stall");

  // R4: lookup held until answered
  assert_map_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mapReqValid && !mapRespValid) |=> (mapReqValid && $stable(mapReqLsp)))
    else $error("mapping request dropped before response");

  // R2: analysis stage busy after taking a request
  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady)
    else $error("request port ready right after acceptance");

  // R8: trigger is a single-cycle pulse
  assert_gc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gcTrigger |=> !gcTrigger)
    else $error("gcTrigger longer than one cycle");

endmodule

bind cmd_interp_pipe cip_checker #(
  .LSP_W      (LSP_W),
  .NUM_MODULES(NUM_MODULES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .mapReqValid (mapReqValid),
  .mapRespValid(mapRespValid),
  .mapReqLsp   (mapReqLsp),
  .agentValid  (agentValid),
  .agentReady  (agentReady),
  .hitValid    (hitValid),
  .hitReady    (hitReady),
  .cmdLsp      (cmdLsp),
  .gcTrigger   (gcTrigger)
);

// File: tb/cmd_interp_pipe_tb.sv
module cmd_interp_pipe_tb;

  localparam int PAGE_W = 24;
  localparam int LEN_W  = 8;
  localparam int SLOT_W = 2;
  localparam int NMOD   = 4;
  localparam int CHIP_W = 2;
  localparam int SPG_W  = 6;
  localparam int BLK_W  = 10;
  localparam int LSP_W  = 22;
  localparam int PSP_W  = 20;
  localparam int IDLE_L = 20;
  localparam int DEPTH  = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [SLOT_W-1:0] reqSlot = '0;
  logic [PAGE_W-1:0] reqPage = '0;
  logic [LEN_W-1:0]  reqPagesM1 = '0;
  logic reqReady, wbProbeValid, wbProbeWrite, wbHit, mapReqValid, mapRespValid;
  logic [LSP_W-1:0] wbProbeLsp, mapReqLsp, cmdLsp;
  logic [PSP_W-1:0] mapRespPsp;
  logic [NMOD-1:0] agentValid, agentReady;
  logic hitValid, hitReady, cmdWrite, gcTrigger;
  logic [SLOT_W-1:0] cmdSlot;
  logic [CHIP_W-1:0] cmdChip;
  logic [BLK_W-1:0]  cmdBlock;
  logic [SPG_W-1:0]  cmdPage;

  cmd_interp_pipe #(.IDLE_LIMIT(IDLE_L)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSlot(reqSlot), .reqPage(reqPage), .reqPagesM1(reqPagesM1),
    .wbProbeValid(wbProbeValid), .wbProbeLsp(wbProbeLsp), .wbProbeWrite(wbProbeWrite),
    .wbHit(wbHit), .mapReqValid(mapReqValid), .mapReqLsp(mapReqLsp),
    .mapRespValid(mapRespValid), .mapRespPsp(mapRespPsp), .agentValid(agentValid),
    .agentReady(agentReady), .hitValid(hitValid), .hitReady(hitReady), .cmdLsp(cmdLsp),
    .cmdWrite(cmdWrite), .cmdSlot(cmdSlot), .cmdChip(cmdChip), .cmdBlock(cmdBlock),
    .cmdPage(cmdPage), .gcTrigger(gcTrigger)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  // Environment models
  logic hitEnable = 1'b0;
  int mapLat = 0;
  int waitCnt = 0;
  logic [NMOD-1:0] readyMask = '1;
  logic hitRdy = 1'b1;
  assign agentReady = readyMask;
  assign hitReady = hitRdy;
  assign wbHit = hitEnable && wbProbeValid && (wbProbeLsp[1:0] == 2'b11);

  function automatic logic [PSP_W-1:0] pspOf(input logic [LSP_W-1:0] l);
    logic [LSP_W-1:0] t;
    t = l * 22'd13 + 22'd5;
    return t[PSP_W-1:0];
  endfunction

  always @(posedge clk) begin
    if (mapReqValid && !mapRespValid) waitCnt <= waitCnt + 1;
    else waitCnt <= 0;
  end
  assign mapRespValid = mapReqValid && (waitCnt >= mapLat);
  assign mapRespPsp = pspOf(mapReqLsp);

  // Output monitor
  logic             gotHit  [DEPTH];
  logic [1:0]       gotMod  [DEPTH];
  logic [LSP_W-1:0] gotLsp  [DEPTH];
  logic [CHIP_W-1:0] gotChip[DEPTH];
  logic [BLK_W-1:0] gotBlk  [DEPTH];
  logic [SPG_W-1:0] gotPg   [DEPTH];
  logic             gotWr   [DEPTH];
  logic [SLOT_W-1:0] gotSlot[DEPTH];
  int               gotEdge [DEPTH];
  int gotN = 0, mapHs = 0, gcCount = 0, gcEdge = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < NMOD; m++) begin
        if (agentValid[m] && agentReady[m] && gotN < DEPTH) begin
          gotHit[gotN] = 1'b0; gotMod[gotN] = 2'(m); gotLsp[gotN] = cmdLsp;
          gotChip[gotN] = cmdChip; gotBlk[gotN] = cmdBlock; gotPg[gotN] = cmdPage;
          gotWr[gotN] = cmdWrite; gotSlot[gotN] = cmdSlot; gotEdge[gotN] = edgeCnt;
          gotN = gotN + 1;
        end
      end
      if (hitValid && hitReady && gotN < DEPTH) begin
        gotHit[gotN] = 1'b1; gotMod[gotN] = 2'd0; gotLsp[gotN] = cmdLsp;
        gotChip[gotN] = '0; gotBlk[gotN] = '0; gotPg[gotN] = '0;
        gotWr[gotN] = cmdWrite; gotSlot[gotN] = cmdSlot; gotEdge[gotN] = edgeCnt;
        gotN = gotN + 1;
      end
      if (mapReqValid && mapRespValid) mapHs = mapHs + 1;
      if (gcTrigger) begin gcCount = gcCount + 1; gcEdge = edgeCnt; end
    end
  end

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic sendReq(input logic w, input logic [1:0] s, input logic [PAGE_W-1:0] pg,
                         input logic [LEN_W-1:0] m1, output int accEdge);
    @(posedge clk); #1;
    reqValid = 1'b1; reqWrite = w; reqSlot = s; reqPage = pg; reqPagesM1 = m1;
    do @(negedge clk); while (!reqReady);
    accEdge = edgeCnt + 1;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  // Compares all commands of one request (R2 R3 R5 R7)
  task automatic checkResults(input int base, input int mapBase, input logic w,
                              input logic [1:0] s, input logic [PAGE_W-1:0] pg,
                              input logic [LEN_W-1:0] m1, input string tag);
    logic [LSP_W-1:0] first, last, lsp;
    logic [PAGE_W-1:0] endPg;
    logic [PSP_W-1:0] psp;
    logic expHit;
    bit ok;
    int nExp, misses, t;
    first = pg[PAGE_W-1:2];
    endPg = pg + PAGE_W'(m1);
    last  = endPg[PAGE_W-1:2];
    nExp  = int'(LSP_W'(last - first)) + 1;
    t = 0;
    while (gotN < base + nExp && t < 400) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    check(gotN == base + nExp, "R2",
          $sformatf("%s command count %0d expected %0d", tag, gotN - base, nExp));
    misses = 0;
    for (int i = 0; i < nExp && base + i < gotN; i++) begin
      lsp = first + LSP_W'(i);
      expHit = hitEnable && (lsp[1:0] == 2'b11);
      psp = pspOf(lsp);
      if (!expHit) misses++;
      ok = (gotLsp[base+i] == lsp) && (gotHit[base+i] == expHit) &&
           (gotWr[base+i] == w) && (gotSlot[base+i] == s) &&
           (expHit || (gotMod[base+i] == psp[1:0] && gotChip[base+i] == psp[3:2] &&
                       gotPg[base+i] == psp[9:4] && gotBlk[base+i] == psp[19:10]));
      check(ok, "R2 R3 R5 R7",
            $sformatf("%s cmd %0d lsp %0h hit %0b mod %0d chip %0d pg %0d blk %0d wr %0b slot %0d expected lsp %0h hit %0b mod %0d chip %0d pg %0d blk %0d wr %0b slot %0d",
                      tag, i, gotLsp[base+i], gotHit[base+i], gotMod[base+i], gotChip[base+i],
                      gotPg[base+i], gotBlk[base+i], gotWr[base+i], gotSlot[base+i],
                      lsp, expHit, psp[1:0], psp[3:2], psp[9:4], psp[19:10], w, s));
    end
    check(mapHs - mapBase == misses, "R3",
          $sformatf("%s lookups %0d expected %0d", tag, mapHs - mapBase, misses));
  endtask

  // Stimulus table: {write, slot, firstPage, pagesMinusOne}
  localparam int NVEC = 6;
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 24'h000010, 8'd0},
    {1'b1, 2'd1, 24'h000013, 8'd1},
    {1'b0, 2'd2, 24'h000020, 8'd3},
    {1'b1, 2'd3, 24'h000021, 8'd8},
    {1'b0, 2'd0, 24'h00003C, 8'd15},
    {1'b1, 2'd2, 24'hFFFFFE, 8'd5}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc, base, mb, g0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1 && agentValid == '0 && hitValid == 1'b0 && mapReqValid == 1'b0 &&
          wbProbeValid == 1'b0 && gcTrigger == 1'b0, "R1",
          $sformatf("ready %0b agent %0b hit %0b map %0b probe %0b gc %0b expected 1 0 0 0 0 0",
                    reqReady, agentValid, hitValid, mapReqValid, wbProbeValid, gcTrigger));
    @(posedge clk); #1 rst_n = 1'b1;

    // Table walk: hits on, one-cycle lookup latency
    hitEnable = 1'b1; mapLat = 1;
    for (int v = 0; v < NVEC; v++) begin
      base = gotN; mb = mapHs;
      sendReq(VEC[v][34], VEC[v][33:32], VEC[v][31:8], VEC[v][7:0], acc);
      checkResults(base, mb, VEC[v][34], VEC[v][33:32], VEC[v][31:8], VEC[v][7:0],
                   $sformatf("vec%0d", v));
    end

    // R9 latency and R2 busy
    hitEnable = 1'b0; mapLat = 0;
    base = gotN; mb = mapHs;
    sendReq(1'b0, 2'd1, 24'h000100, 8'd7, acc);
    check(reqReady == 1'b0, "R2", $sformatf("reqReady %0b expected 0 while splitting", reqReady));
    checkResults(base, mb, 1'b0, 2'd1, 24'h000100, 8'd7, "latency");
    check(gotEdge[base] - acc == 3, "R9",
          $sformatf("first command after %0d edges expected 3", gotEdge[base] - acc));
    check(gotEdge[base+1] - gotEdge[base] == 1, "R9",
          $sformatf("second command gap %0d expected 1", gotEdge[base+1] - gotEdge[base]));

    // R6 back-pressure
    hitEnable = 1'b1; readyMask = '0; hitRdy = 1'b0;
    base = gotN; mb = mapHs;
    sendReq(1'b1, 2'd3, 24'h00020C, 8'd11, acc);
    repeat (12) @(negedge clk);
    check(gotN == base && (agentValid != '0 || hitValid), "R6",
          $sformatf("delivered %0d offered %0b/%0b expected 0 delivered and one offered",
                    gotN - base, agentValid, hitValid));
    @(posedge clk); #1 readyMask = '1; hitRdy = 1'b1;
    checkResults(base, mb, 1'b1, 2'd3, 24'h00020C, 8'd11, "stall");

    // R4 slow fill holds order
    hitEnable = 1'b0; mapLat = 6;
    base = gotN; mb = mapHs;
    sendReq(1'b0, 2'd2, 24'h000400, 8'd7, acc);
    repeat (3) @(negedge clk);
    check(mapReqValid == 1'b1 && mapReqLsp == 22'h100 && gotN == base, "R4",
          $sformatf("map %0b lsp %0h delivered %0d expected 1 100 0",
                    mapReqValid, mapReqLsp, gotN - base));
    checkResults(base, mb, 1'b0, 2'd2, 24'h000400, 8'd7, "slowmap");
    mapLat = 0;

    // R8 idle trigger: none while busy, one pulse after idle, rearmed
    sendReq(1'b0, 2'd0, 24'h000800, 8'd0, acc);
    g0 = gcCount;
    for (int k = 0; k < 4; k++) begin
      repeat (8) @(negedge clk);
      sendReq(1'b0, 2'd0, 24'h000800, 8'd0, acc);
    end
    check(gcCount == g0, "R8", $sformatf("pulses %0d expected 0 while active", gcCount - g0));
    repeat (IDLE_L + 30) @(negedge clk);
    check(gcCount - g0 == 1 && gcEdge - acc == IDLE_L, "R8",
          $sformatf("pulses %0d at %0d edges expected 1 at %0d", gcCount - g0, gcEdge - acc, IDLE_L));
    g0 = gcCount;
    sendReq(1'b1, 2'd1, 24'h000804, 8'd0, acc);
    repeat (IDLE_L + 30) @(negedge clk);
    check(gcCount - g0 == 1 && gcEdge - acc == IDLE_L, "R8",
          $sformatf("rearm pulses %0d at %0d edges expected 1 at %0d", gcCount - g0, gcEdge - acc, IDLE_L));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule